// File: doc/BRIEF.md
# Triggered DMA Channel

This block is one DMA channel that copies bytes from a source address to a destination address over a byte-wide memory bus. The bus uses a request/ready handshake. Each byte is moved as a read access followed by a write access. Software sets up the channel through a small write-only register port. The channel then waits for a trigger input before it moves data.

Data moves in three nested units. The burst is the smallest unit: it is 1, 2, 4 or 8 bytes, and the bus accesses of one burst follow each other without a break. The block is a byte count. The transaction is one block, or a counted run of blocks when repeat mode is on. In single-shot mode every trigger moves one burst. Otherwise one trigger moves a whole block. The source address and the destination address each have their own step direction and their own reload point, so a fixed peripheral register can feed a linear buffer. When a transaction ends, the channel clears its own enable and sets a sticky completion flag for software to poll.

Top module: `dmac_channel`

## Requirements
- R1: After reset the channel is disabled, the completion flag is clear and no bus request is raised.
- R2: Every byte is a read at the source address followed by a write of that same byte to the destination address. The bursts of one block follow each other as read/write pairs with no trigger in between. The burst length code is control register (select 0) bits [5:4]: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8.
- R3: With single-shot set (control bit 1), each trigger moves exactly one burst. A burst that would cross the end of the block stops at the end of the block.
- R4: With single-shot clear, one trigger moves every remaining byte of the current block.
- R5: The block count (select 2) is counted in bytes. With repeat mode off (control bit 2 clear), a transaction is one block. With repeat mode on and a repeat count N of 1 or more (select 3), a transaction is N blocks. Each block starts only on its own trigger.
- R6: Writing control with bit 0 set while the channel is disabled enables it. At the end of a transaction the channel clears its own enable and sets the completion flag. The flag stays set until software clears it.
- R7: With repeat mode on and a repeat count of 0, the transaction never ends: the enable stays set and the flag is never set.
- R8: A trigger while the channel is disabled is ignored and is not remembered. Triggers that arrive during a burst collapse into one pending request, which is served after that burst.
- R9: Address mode (select 1) holds the source reload in bits [1:0], the source direction in [3:2], the destination reload in [5:4] and the destination direction in [7:6]. Reload codes: 0 = none, 1 = after each burst, 2 = after each block, 3 = after the transaction. Direction codes: 1 = increment, 2 = decrement, 0 or 3 = fixed. A reload restores the start address (source at select 4, destination at select 5) and takes priority over the step of the same byte.
- R10: A bus request holds its address, write flag and write data unchanged until ready is seen high.
- R11: Writes to selects 0 to 5 are ignored while the channel is enabled, except for the stop request of R12.
- R12: Writing control with bit 0 clear while the channel is enabled stops it at the next burst boundary, or at once if it is waiting for a trigger. The completion flag is left unchanged.
- R13: Writing select 6 with bit 0 set clears the completion flag. If a transaction ends in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | CFG_W (16) | Register write data |
| trigger | input | 1 | Transfer request pulse |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | ADDR_W (16) | Bus address |
| bus_wdata | output | DATA_W (8) | Write data |
| bus_rdata | input | DATA_W (8) | Read data, valid with ready on a read |
| bus_ready | input | 1 | Access accepted this cycle |
| ch_enabled | output | 1 | Channel enabled status |
| xfer_done | output | 1 | Sticky transaction-complete flag |

## Verification
Two events can fall on the same clock edge: the final write of a transaction sets the completion flag, and a software write to select 6 clears it. The bench provokes this from its bus model. At the falling edge where it grants ready to the write that its own model predicts is the last of the transaction, it also drives the clear write. The flag must then read as set afterwards, and a later clear on its own must still clear it. A second overlap is a trigger arriving while a burst is in flight. The bench judges this by the number of bytes written: extra triggers during one burst add exactly one more burst.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
// Shared types for the DMA channel: address mode codes, mode bundle,
// sequencer states and register select codes.
package dmac_pkg;

    typedef enum logic [1:0] {
        RLD_NONE  = 2'd0,
        RLD_BURST = 2'd1,
        RLD_BLOCK = 2'd2,
        RLD_XACT  = 2'd3
    } reload_e;

    typedef enum logic [1:0] {
        DIR_HOLD  = 2'd0,
        DIR_UP    = 2'd1,
        DIR_DOWN  = 2'd2,
        DIR_HOLD2 = 2'd3
    } step_e;

    typedef struct packed {
        logic       one_burst;
        logic       rpt;
        logic [1:0] blen;
        reload_e    src_rld;
        step_e      src_dir;
        reload_e    dst_rld;
        step_e      dst_dir;
    } mode_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } ch_state_e;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_AMODE = 3'd1;
    localparam logic [2:0] SEL_BLOCK = 3'd2;
    localparam logic [2:0] SEL_RPT   = 3'd3;
    localparam logic [2:0] SEL_SRC   = 3'd4;
    localparam logic [2:0] SEL_DST   = 3'd5;
    localparam logic [2:0] SEL_FLAG  = 3'd6;

    localparam int BLEN_CODE_W = 2;
    // Widest burst is 2**(2**BLEN_CODE_W - 1) bytes; one more bit holds it.
    localparam int BURST_W = (1 << BLEN_CODE_W);

endpackage

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
// Configuration register file of the DMA channel.
// Assumes: software writes one register per cycle. Configuration is
// locked while the channel is enabled or about to be enabled; only the
// stop request and the flag clear pass through then.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int RW    = 8,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             busy,
    output mode_t            mode,
    output logic [CW-1:0]    blk_cnt,
    output logic [RW-1:0]    rep_cnt,
    output logic [AW-1:0]    src_start,
    output logic [AW-1:0]    dst_start,
    output logic             launch,
    output logic             stop_req,
    output logic             flag_clr
);

    logic open_cfg;

    // Configuration may change only when nothing is running or starting.
    assign open_cfg = !busy && !launch;

    // Flag clear acts in the write cycle itself so the sequencer can rank it.
    assign flag_clr = cfg_we && (cfg_sel == SEL_FLAG) && cfg_wdata[0];

    // Capture register writes and produce the one-cycle start/stop pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '0;
            blk_cnt   <= '0;
            rep_cnt   <= '0;
            src_start <= '0;
            dst_start <= '0;
            launch    <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            launch   <= 1'b0;
            stop_req <= 1'b0;
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_CTRL: begin
                        if (open_cfg) begin
                            mode.one_burst <= cfg_wdata[1];
                            mode.rpt       <= cfg_wdata[2];
                            mode.blen      <= cfg_wdata[5:4];
                            launch         <= cfg_wdata[0];
                        end else if (busy && !cfg_wdata[0]) begin
                            stop_req <= 1'b1;
                        end
                    end
                    SEL_AMODE: if (open_cfg) begin
                        mode.src_rld <= reload_e'(cfg_wdata[1:0]);
                        mode.src_dir <= step_e'(cfg_wdata[3:2]);
                        mode.dst_rld <= reload_e'(cfg_wdata[5:4]);
                        mode.dst_dir <= step_e'(cfg_wdata[7:6]);
                    end
                    SEL_BLOCK: if (open_cfg) blk_cnt   <= cfg_wdata[CW-1:0];
                    SEL_RPT:   if (open_cfg) rep_cnt   <= cfg_wdata[RW-1:0];
                    SEL_SRC:   if (open_cfg) src_start <= cfg_wdata[AW-1:0];
                    SEL_DST:   if (open_cfg) dst_start <= cfg_wdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmac_addr_gen.sv
`timescale 1ns/1ps
// Address generator for one side (source or destination) of the channel.
// Assumes: the boundary events arrive with the write of the last byte of
// that boundary; load comes from the channel start.
module dmac_addr_gen
    import dmac_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start,
    input  step_e         dir,
    input  reload_e       rld,
    input  logic          step,
    input  logic          ev_burst,
    input  logic          ev_block,
    input  logic          ev_xact,
    output logic [AW-1:0] addr
);

    logic reload_hit;

    // Decide whether the selected reload boundary is reached this cycle.
    always_comb begin
        case (rld)
            RLD_BURST: reload_hit = ev_burst;
            RLD_BLOCK: reload_hit = ev_block;
            RLD_XACT:  reload_hit = ev_xact;
            default:   reload_hit = 1'b0;
        endcase
    end

    // Working address: start, reload, or one step per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load || reload_hit) begin
            addr <= start;
        end else if (step) begin
            case (dir)
                DIR_UP:   addr <= addr + AW'(1);
                DIR_DOWN: addr <= addr - AW'(1);
                default:  addr <= addr;
            endcase
        end
    end

endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
// Burst/block/transaction sequencer of the DMA channel.
// Assumes: the mode and counts stay steady while enabled (the register
// file locks them). A block count of 0 means 2**CW bytes.
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  logic                   stop_req,
    input  logic                   flag_clr,
    input  logic                   trigger,
    input  logic                   one_burst,
    input  logic                   rpt,
    input  logic [BLEN_CODE_W-1:0] blen_code,
    input  logic [CW-1:0]          blk_cnt,
    input  logic [RW-1:0]          rep_cnt,
    input  logic                   bus_ready,
    output logic                   rd_acc,
    output logic                   wr_acc,
    output logic                   ev_burst,
    output logic                   ev_block,
    output logic                   ev_xact,
    output logic                   in_read,
    output logic                   in_write,
    output logic                   enabled,
    output logic                   done
);

    ch_state_e            state;
    logic                 trig_pend;
    logic                 stop_pend;
    logic                 forever_rpt;
    logic [BURST_W-1:0]   burst_left;
    logic [CW-1:0]        blk_left;
    logic [RW-1:0]        rep_left;
    logic [BURST_W-1:0]   blen_bytes;
    logic                 blk_last;
    logic                 burst_last;
    logic                 begin_burst;

    // Decode state and the boundary conditions of the current byte.
    always_comb begin
        blen_bytes  = BURST_W'(1) << blen_code;
        in_read     = (state == ST_READ);
        in_write    = (state == ST_WRITE);
        enabled     = (state != ST_OFF);
        rd_acc      = in_read && bus_ready;
        wr_acc      = in_write && bus_ready;
        blk_last    = (blk_left == CW'(1));
        burst_last  = (burst_left == BURST_W'(1)) || blk_last;
        ev_burst    = wr_acc && burst_last;
        ev_block    = wr_acc && blk_last;
        ev_xact     = ev_block && !forever_rpt && (rep_left == RW'(1));
        begin_burst = (state == ST_ARMED) && trig_pend && !stop_pend;
    end

    // Hold at most one trigger; none is kept while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_OFF) begin
            trig_pend <= 1'b0;
        end else begin
            trig_pend <= (trig_pend && !begin_burst) || trigger;
        end
    end

    // Main sequencer: byte read/write pairs, burst and block counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            stop_pend   <= 1'b0;
            forever_rpt <= 1'b0;
            burst_left  <= '0;
            blk_left    <= '0;
            rep_left    <= '0;
        end else begin
            if (stop_req) stop_pend <= 1'b1;
            case (state)
                ST_OFF: if (launch) begin
                    state       <= ST_ARMED;
                    stop_pend   <= 1'b0;
                    blk_left    <= blk_cnt;
                    rep_left    <= rpt ? rep_cnt : RW'(1);
                    forever_rpt <= rpt && (rep_cnt == '0);
                end
                ST_ARMED: begin
                    if (stop_pend) begin
                        state <= ST_OFF;
                    end else if (trig_pend) begin
                        state      <= ST_READ;
                        burst_left <= blen_bytes;
                    end
                end
                ST_READ: if (bus_ready) state <= ST_WRITE;
                ST_WRITE: if (bus_ready) begin
                    burst_left <= burst_left - BURST_W'(1);
                    blk_left   <= blk_left - CW'(1);
                    if (blk_last) begin
                        blk_left <= blk_cnt;
                        if (!forever_rpt) rep_left <= rep_left - RW'(1);
                        state <= (ev_xact || stop_pend) ? ST_OFF : ST_ARMED;
                    end else if (burst_last) begin
                        if (stop_pend || one_burst) begin
                            state <= stop_pend ? ST_OFF : ST_ARMED;
                        end else begin
                            state      <= ST_READ;
                            burst_left <= blen_bytes;
                        end
                    end else begin
                        state <= ST_READ;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // Sticky completion flag; setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (ev_xact) begin
            done <= 1'b1;
        end else if (flag_clr) begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/dmac_channel.sv
`timescale 1ns/1ps
// Triggered single DMA channel: register file, sequencer and one address
// generator per side. Assumes a single master on a byte-wide bus whose
// slave answers every request eventually with ready.
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REP_W  = 8,
    parameter int DATA_W = 8,
    localparam int CFG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              trigger,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              ch_enabled,
    output logic              xfer_done
);

    localparam int N_SIDES = 2;   // 0 = source, 1 = destination

    mode_t              mode;
    logic [CNT_W-1:0]   blk_cnt;
    logic [REP_W-1:0]   rep_cnt;
    logic [ADDR_W-1:0]  src_start;
    logic [ADDR_W-1:0]  dst_start;
    logic               launch;
    logic               stop_req;
    logic               flag_clr;
    logic               rd_acc;
    logic               wr_acc;
    logic               ev_burst;
    logic               ev_block;
    logic               ev_xact;
    logic               in_read;
    logic               in_write;
    logic [DATA_W-1:0]  hold_q;

    logic [ADDR_W-1:0]  side_start [N_SIDES];
    step_e              side_dir   [N_SIDES];
    reload_e            side_rld   [N_SIDES];
    logic               side_step  [N_SIDES];
    logic [ADDR_W-1:0]  side_addr  [N_SIDES];

    dmac_regs #(
        .AW(ADDR_W), .CW(CNT_W), .RW(REP_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (ch_enabled),
        .mode      (mode),
        .blk_cnt   (blk_cnt),
        .rep_cnt   (rep_cnt),
        .src_start (src_start),
        .dst_start (dst_start),
        .launch    (launch),
        .stop_req  (stop_req),
        .flag_clr  (flag_clr)
    );

    dmac_seq #(
        .CW(CNT_W), .RW(REP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .stop_req  (stop_req),
        .flag_clr  (flag_clr),
        .trigger   (trigger),
        .one_burst (mode.one_burst),
        .rpt       (mode.rpt),
        .blen_code (mode.blen),
        .blk_cnt   (blk_cnt),
        .rep_cnt   (rep_cnt),
        .bus_ready (bus_ready),
        .rd_acc    (rd_acc),
        .wr_acc    (wr_acc),
        .ev_burst  (ev_burst),
        .ev_block  (ev_block),
        .ev_xact   (ev_xact),
        .in_read   (in_read),
        .in_write  (in_write),
        .enabled   (ch_enabled),
        .done      (xfer_done)
    );

    // Route per-side controls into the generator arrays.
    assign side_start[0] = src_start;
    assign side_start[1] = dst_start;
    assign side_dir[0]   = mode.src_dir;
    assign side_dir[1]   = mode.dst_dir;
    assign side_rld[0]   = mode.src_rld;
    assign side_rld[1]   = mode.dst_rld;
    assign side_step[0]  = rd_acc;
    assign side_step[1]  = wr_acc;

    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        dmac_addr_gen #(.AW(ADDR_W)) u_ag (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (launch),
            .start    (side_start[g]),
            .dir      (side_dir[g]),
            .rld      (side_rld[g]),
            .step     (side_step[g]),
            .ev_burst (ev_burst),
            .ev_block (ev_block),
            .ev_xact  (ev_xact),
            .addr     (side_addr[g])
        );
    end

    // Keep the byte read last so the following write can return it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_acc) begin
            hold_q <= bus_rdata;
        end
    end

    // Bus outputs follow the sequencer state directly.
    assign bus_req   = in_read || in_write;
    assign bus_we    = in_write;
    assign bus_addr  = in_write ? side_addr[1] : side_addr[0];
    assign bus_wdata = hold_q;

endmodule

// File: rtl/dmac_channel_chk.sv
`timescale 1ns/1ps
// Protocol and status checker bound to the DMA channel top.
// Assumes the top's port names; observes ports only.
module dmac_channel_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CFG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              ch_enabled,
    input logic              xfer_done
);

    // R10: a waiting request keeps its address, direction and data.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R2: an accepted read is followed at once by the matching write.
    p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_ready |=> bus_req && bus_we);

    // R8: a disabled channel never touches the bus.
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_enabled |-> !bus_req);

    // R6: the flag is raised only as the channel drops its own enable.
    p_done_with_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $fell(ch_enabled));

    // R6: enabling only comes from a control write two cycles earlier.
    p_enable_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_enabled) |-> $past(cfg_we, 2) && ($past(cfg_sel, 2) == 3'd0));

    // R13: the flag falls only after a clear write.
    p_flag_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_done) |-> $past(cfg_we && (cfg_sel == 3'd6) && cfg_wdata[0]));

endmodule

bind dmac_channel dmac_channel_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)
) u_chk (.*);

// File: tb/tb_dmac_channel.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random configs.
// A negedge bus model answers the channel and checks every byte against
// an address/boundary model kept in the bench.
module tb_dmac_channel;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int CFW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           cfg_we_t = 1'b0;
    logic [2:0]     cfg_sel_t = '0;
    logic [CFW-1:0] cfg_wdata_t = '0;
    logic           coll_we = 1'b0;
    logic           cfg_we;
    logic [2:0]     cfg_sel;
    logic [CFW-1:0] cfg_wdata;
    logic           trigger = 1'b0;
    logic           bus_req;
    logic           bus_we;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata;
    logic [DW-1:0]  bus_rdata = '0;
    logic           bus_ready = 1'b0;
    logic           ch_enabled;
    logic           xfer_done;

    assign cfg_we    = cfg_we_t | coll_we;
    assign cfg_sel   = coll_we ? 3'd6 : cfg_sel_t;
    assign cfg_wdata = coll_we ? CFW'(1) : cfg_wdata_t;

    dmac_channel dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .trigger(trigger), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .ch_enabled(ch_enabled), .xfer_done(xfer_done)
    );

    logic [7:0] mem [0:1023];
    int n_chk = 0;
    int n_fail = 0;
    int n_rd = 0;
    int n_wr = 0;
    int cyc = 0;

    // model configuration and state
    int c_blen, c_blk, c_reps, sdir, srld, ddir, drld;
    logic [AW-1:0] c_src0, c_dst0, e_src, e_dst;
    logic [7:0] e_data;
    int e_bc, e_blk, e_rep;
    bit coll_arm = 0;
    bit fast_ready = 0;
    bit prev_wait = 0;
    logic [AW-1:0] prev_addr;
    logic prev_we;
    logic [7:0] prev_wd;

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return (a[7:0] * 8'd13) + {6'd0, a[9:8]} + 8'd7;
    endfunction

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input int d);
        if (d == 1) return a + 16'd1;
        if (d == 2) return a - 16'd1;
        return a;
    endfunction

    function automatic bit hit(input int r, input bit be, input bit ke, input bit xe);
        return (r == 1 && be) || (r == 2 && ke) || (r == 3 && xe);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bus model and per-byte reference check (R2, R9, R10).
    always @(negedge clk) begin
        bit be, ke, xe;
        coll_we = 1'b0;
        if (rst_n && prev_wait)
            chk(bus_req && bus_addr == prev_addr && bus_we == prev_we && bus_wdata == prev_wd,
                "R10 hold", int'(bus_addr), int'(prev_addr));
        if (rst_n && bus_req && (fast_ready || ($urandom % 4) != 0)) begin
            bus_ready = 1'b1;
            prev_wait = 0;
            if (!bus_we) begin
                chk(bus_addr == e_src, "R9 source address", int'(bus_addr), int'(e_src));
                bus_rdata = mem[bus_addr[9:0]];
                e_data = pat(bus_addr);
                e_src = nxt(e_src, sdir);
                n_rd++;
            end else begin
                chk(bus_addr == e_dst, "R9 destination address", int'(bus_addr), int'(e_dst));
                chk(bus_wdata == e_data, "R2 byte copied", int'(bus_wdata), int'(e_data));
                mem[bus_addr[9:0]] = bus_wdata;
                n_wr++;
                e_dst = nxt(e_dst, ddir);
                e_bc++;
                e_blk++;
                ke = (e_blk == c_blk);
                be = (e_bc == c_blen) || ke;
                xe = ke && (c_reps != 0) && (e_rep + 1 == c_reps);
                if (be) e_bc = 0;
                if (ke) begin e_blk = 0; e_rep++; end
                if (hit(srld, be, ke, xe)) e_src = c_src0;
                if (hit(ddir >= 0 ? drld : 0, be, ke, xe)) e_dst = c_dst0;
                if (xe && coll_arm) begin
                    coll_we = 1'b1;
                    coll_arm = 0;
                end
            end
        end else begin
            bus_ready = 1'b0;
            prev_wait = rst_n && bus_req;
            prev_addr = bus_addr;
            prev_we = bus_we;
            prev_wd = bus_wdata;
        end
    end

    task automatic final_report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            final_report();
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [CFW-1:0] d);
        @(negedge clk);
        cfg_we_t = 1'b1;
        cfg_sel_t = sel;
        cfg_wdata_t = d;
        @(negedge clk);
        cfg_we_t = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (bus_req) q = 0; else q++;
        end
    endtask

    task automatic setup(input bit single, input bit rpt, input int bcode, input int blk,
                         input int rep, input int sd, input int sr, input int dd,
                         input int dr, input logic [AW-1:0] s0, input logic [AW-1:0] d0);
        c_blen = 1 << bcode; c_blk = blk; c_reps = rpt ? rep : 1;
        sdir = sd; srld = sr; ddir = dd; drld = dr; c_src0 = s0; c_dst0 = d0;
        e_src = s0; e_dst = d0; e_bc = 0; e_blk = 0; e_rep = 0;
        cfg_write(3'd1, CFW'({dd[1:0], dr[1:0], sd[1:0], sr[1:0]}));
        cfg_write(3'd2, CFW'(blk));
        cfg_write(3'd3, CFW'(rep));
        cfg_write(3'd4, s0);
        cfg_write(3'd5, d0);
        n_rd = 0; n_wr = 0;
        cfg_write(3'd0, CFW'({bcode[1:0], 1'b0, rpt, single, 1'b1}));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = pat(AW'(i));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ch_enabled == 0, "R1 enable", int'(ch_enabled), 0);
        chk(xfer_done == 0, "R1 flag", int'(xfer_done), 0);
        chk(bus_req == 0, "R1 request", int'(bus_req), 0);

        // R8: trigger while disabled is neither served nor remembered
        pulse();
        repeat (10) @(negedge clk);
        chk(n_rd == 0, "R8 disabled trigger", n_rd, 0);
        setup(1, 0, 1, 8, 0, 1, 1, 1, 0, 16'h0040, 16'h0200);
        repeat (10) @(negedge clk);
        chk(n_rd == 0, "R8 no stale trigger", n_rd, 0);

        // R3: one 2-byte burst per trigger, four triggers finish the block
        pulse(); wait_idle();
        chk(n_wr == 2, "R3 one burst per trigger", n_wr, 2);
        repeat (3) begin pulse(); wait_idle(); end
        chk(n_wr == 8, "R3 bytes after four triggers", n_wr, 8);
        chk(n_rd == n_wr, "R2 read/write pairs", n_rd, n_wr);
        chk(ch_enabled == 0, "R6 self disable", int'(ch_enabled), 0);
        chk(xfer_done == 1, "R6 flag set", int'(xfer_done), 1);
        repeat (5) @(negedge clk);
        chk(xfer_done == 1, "R6 flag sticky", int'(xfer_done), 1);
        cfg_write(3'd6, CFW'(1));
        chk(xfer_done == 0, "R13 clear", int'(xfer_done), 0);

        // R4: free-running block of 12 bytes in 4-byte bursts, decrementing dest
        setup(0, 0, 2, 12, 0, 1, 0, 2, 0, 16'h0060, 16'h0300);
        pulse(); wait_idle();
        chk(n_wr == 12, "R4 whole block per trigger", n_wr, 12);
        chk(xfer_done == 1 && ch_enabled == 0, "R6 end of block", int'(xfer_done), 1);
        cfg_write(3'd6, CFW'(1));

        // R5: three blocks of 5 bytes, each waits for a trigger; dest reloads per block
        setup(0, 1, 0, 5, 3, 0, 0, 1, 2, 16'h0033, 16'h0280);
        pulse(); wait_idle();
        chk(n_wr == 5, "R5 first block only", n_wr, 5);
        chk(ch_enabled == 1 && xfer_done == 0, "R5 still running", int'(ch_enabled), 1);
        pulse(); wait_idle(); pulse(); wait_idle();
        chk(n_wr == 15, "R5 block count times repeat count", n_wr, 15);
        chk(xfer_done == 1 && ch_enabled == 0, "R5 transaction end", int'(xfer_done), 1);
        cfg_write(3'd6, CFW'(1));

        // R3: burst truncated at block end (4-byte bursts, 6-byte block)
        setup(1, 0, 2, 6, 0, 2, 2, 1, 0, 16'h0090, 16'h0240);
        pulse(); wait_idle();
        chk(n_wr == 4, "R3 full burst", n_wr, 4);
        pulse(); wait_idle();
        chk(n_wr == 6, "R3 truncated burst", n_wr, 6);
        chk(xfer_done == 1, "R3 block done after truncation", int'(xfer_done), 1);
        cfg_write(3'd6, CFW'(1));

        // R7, R11, R12: endless repeat, locked config, software stop
        setup(0, 1, 1, 4, 0, 1, 3, 1, 1, 16'h0020, 16'h0220);
        repeat (3) begin pulse(); wait_idle(); end
        chk(n_wr == 12, "R7 three blocks", n_wr, 12);
        chk(ch_enabled == 1 && xfer_done == 0, "R7 never ends", int'(ch_enabled), 1);
        cfg_write(3'd2, CFW'(1));
        pulse(); wait_idle();
        chk(n_wr == 16, "R11 block count locked", n_wr, 16);
        cfg_write(3'd0, CFW'(0));
        repeat (4) @(negedge clk);
        chk(ch_enabled == 0, "R12 stop", int'(ch_enabled), 0);
        chk(xfer_done == 0, "R12 flag untouched", int'(xfer_done), 0);

        // R8: several triggers during one burst merge into one pending request
        setup(1, 0, 3, 24, 0, 1, 0, 1, 0, 16'h0050, 16'h0260);
        pulse();
        repeat (3) @(negedge clk);
        pulse(); pulse();
        wait_idle();
        chk(n_wr == 16, "R8 single pending request", n_wr, 16);
        chk(ch_enabled == 1, "R8 block not finished", int'(ch_enabled), 1);
        pulse(); wait_idle();
        chk(n_wr == 24 && xfer_done == 1, "R8 final burst", n_wr, 24);
        cfg_write(3'd6, CFW'(1));

        // R13: clear write in the same cycle as transaction end
        setup(0, 0, 0, 6, 0, 1, 0, 1, 0, 16'h0070, 16'h02A0);
        coll_arm = 1;
        pulse(); wait_idle();
        chk(coll_arm == 0, "R13 collision provoked", int'(coll_arm), 0);
        chk(xfer_done == 1, "R13 set wins over clear", int'(xfer_done), 1);
        cfg_write(3'd6, CFW'(1));
        chk(xfer_done == 0, "R13 later clear", int'(xfer_done), 0);

        // Random configurations (R2 to R5, R9)
        for (int it = 0; it < 20; it++) begin
            bit sg, rp;
            int bc, bk, rc, tries;
            sg = 1'($urandom % 2);
            rp = 1'($urandom % 2);
            bc = int'($urandom % 4);
            bk = 1 + int'($urandom % 20);
            rc = 1 + int'($urandom % 3);
            fast_ready = ($urandom % 4) == 0;
            setup(sg, rp, bc, bk, rc, int'($urandom % 4), int'($urandom % 4),
                  int'($urandom % 4), int'($urandom % 4),
                  16'h0080 + 16'($urandom % 32), 16'h0300 + 16'($urandom % 32));
            tries = 0;
            while (ch_enabled && tries < 400) begin
                pulse();
                repeat ($urandom % 12) @(negedge clk);
                tries++;
            end
            wait_idle();
            chk(n_wr == bk * (rp ? rc : 1), "R5 random byte total", n_wr, bk * (rp ? rc : 1));
            chk(xfer_done == 1 && ch_enabled == 0, "R6 random end", int'(xfer_done), 1);
            cfg_write(3'd6, CFW'(1));
        end
        fast_ready = 0;

        final_report();
    end

endmodule